// File: doc/BRIEF.md
# Majority-Vote Recirculating Memory Word Array

This block is a small addressable memory built from one-bit cells whose logic uses only three-input majority gates, a five-input majority gate and an inverter. Each cell does not use an enabled flip-flop to keep its bit. It keeps the bit in a ring of four zone registers. The last zone feeds back through the cell logic into the first zone, so the bit is refreshed on every clock edge. Each register stands for one phase-shifted clock zone, so one full storage cycle takes four clock edges.

The two force lines, `setLine` and `clrLine`, are shared by all words. When both are high, every cell goes to 1. When both are low, every cell goes to 0. When the two lines differ, the array works normally. In that case, the word picked by `addr`, qualified by `enable`, is written from `din` when `wrRd` is high and is only read when `wrRd` is low. All other words recirculate unchanged.

A controller samples the operation on every fourth clock edge after reset. It holds the operation for a whole four-edge storage cycle, so every zone of every cell gets the same update. All cell bits are visible at once on `cellOut`.

Top module: `majram_array`

## Requirements
- R1: While reset is active and right after it is released, every bit of `cellOut` is 0.
- R2: An operation with `setLine`=1 and `clrLine`=1 drives every cell of every word to 1, whatever `enable`, `wrRd`, `addr` and `din` are.
- R3: An operation with `setLine`=0 and `clrLine`=0 drives every cell of every word to 0, whatever `enable`, `wrRd`, `addr` and `din` are.
- R4: With `setLine`=0, `clrLine`=1, `enable`=1 and `wrRd`=1, the word at `addr` takes the value of `din`. Word w occupies bits `cellOut[w*WIDTH +: WIDTH]`.
- R5: With `setLine`=0, `clrLine`=1, `enable`=1 and `wrRd`=0, the addressed word keeps its stored value and `din` has no effect.
- R6: A word is left unchanged by any non-forcing operation that does not select it, either because `enable`=0 or because `addr` names another word.
- R7: `setLine`=1 together with `clrLine`=0 behaves exactly like `setLine`=0 together with `clrLine`=1.
- R8: An operation is sampled on the first clock edge after reset release and then on every fourth edge. Its result appears on `cellOut` after the fifth edge, counting the sampling edge as the first. After the fourth edge the output still shows the previous value.
- R9: A stored value stays unchanged on `cellOut` through any number of idle storage cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Zone clock; each edge advances the ring by one zone |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Qualifies the address decode; 0 selects no word |
| wrRd | input | 1 | 1 writes the selected word, 0 reads it |
| setLine | input | 1 | Force line; with `clrLine` selects force-1, force-0 or normal |
| clrLine | input | 1 | Second force line |
| addr | input | $clog2(WORDS) | Word index |
| din | input | WIDTH | Write data |
| cellOut | output | WORDS*WIDTH | All stored bits, word 0 in the low bits |

## Verification
The hardest case to reach is the boundary between two storage cycles. A new operation is sampled on the same edge where the old one makes its last write into the ring, so an error of one edge in the hold window would leave zones that disagree. The stimulus therefore keeps each operation aligned to four edges after reset. It probes `cellOut` on both sides of the fifth edge, and it runs force and write operations back to back so that a stale zone would show up. A long idle run then confirms that all four zones of every cell carry the same bit.

// File: rtl/majram_pkg.sv
package majram_pkg;

  // Strobes passed from the controller to the cell datapath.
  typedef struct packed {
    logic setL;     // held force line A for the current storage cycle
    logic clrL;     // held force line B for the current storage cycle
    logic wrRd;     // held write/read-not for the current storage cycle
    logic capture;  // high on the edge that samples a new operation
  } strobes_t;

endpackage

// File: rtl/maj3.sv
module maj3 (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic y
);
  assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/maj5.sv
module maj5 (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic e,
  output logic y
);
  logic [2:0] ones;
  assign ones = {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d} + {2'b00, e};
  assign y    = (ones >= 3'd3);
endmodule

// File: rtl/majram_ctrl.sv
module majram_ctrl
  import majram_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int ZONES = 4,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int PW   = (ZONES > 1) ? $clog2(ZONES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             wrRd,
  input  logic             setLine,
  input  logic             clrLine,
  input  logic [AW-1:0]    addr,
  output strobes_t         strobes,
  output logic [WORDS-1:0] wordSel,
  output logic             atBoundary
);

  localparam logic [PW-1:0] LAST_PHASE = PW'(ZONES - 1);

  logic [PW-1:0] phase;
  logic          heldSet, heldClr, heldWr;

  assign atBoundary = (phase == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (phase == LAST_PHASE) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // Operation register: loaded once per storage cycle, held for ZONES edges.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldSet <= 1'b0;
      heldClr <= 1'b1;
      heldWr  <= 1'b0;
      wordSel <= '0;
    end else if (atBoundary) begin
      heldSet <= setLine;
      heldClr <= clrLine;
      heldWr  <= wrRd;
      for (int w = 0; w < WORDS; w++) begin
        wordSel[w] <= enable && (addr == AW'(w));
      end
    end
  end

  always_comb begin
    strobes.setL    = heldSet;
    strobes.clrL    = heldClr;
    strobes.wrRd    = heldWr;
    strobes.capture = atBoundary;
  end

endmodule

// File: rtl/majram_dp.sv
module majram_dp
  import majram_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int WIDTH = 4,
  parameter int ZONES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               strobes,
  input  logic [WORDS-1:0]       wordSel,
  input  logic [WIDTH-1:0]       din,
  output logic [WORDS*WIDTH-1:0] cellOut
);

  logic [WIDTH-1:0] dinHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dinHeld <= '0;
    end else if (strobes.capture) begin
      dinHeld <= din;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [ZONES-1:0] ring;
      logic wrGate, wrGateN, newPath, oldPath, voted;

      // AND of select and write: majority with one input tied low
      maj3 u_wrAnd  (.a(wordSel[w]), .b(strobes.wrRd), .c(1'b0), .y(wrGate));
      assign wrGateN = ~wrGate;
      maj3 u_newAnd (.a(wrGate),  .b(dinHeld[b]),     .c(1'b0), .y(newPath));
      maj3 u_oldAnd (.a(wrGateN), .b(ring[ZONES-1]),  .c(1'b0), .y(oldPath));
      // Final vote: force lines plus a constant 1 bias the data paths
      maj5 u_vote (
        .a(newPath), .b(oldPath), .c(strobes.setL), .d(strobes.clrL), .e(1'b1),
        .y(voted)
      );

      always_ff @(posedge clk) begin
        if (!rstN) begin
          ring <= '0;
        end else begin
          ring <= {ring[ZONES-2:0], voted};
        end
      end

      assign cellOut[w*WIDTH + b] = ring[ZONES-1];
    end
  end

endmodule

// File: rtl/majram_array.sv
module majram_array
  import majram_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int WIDTH = 4,
  parameter int ZONES = 4,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic                   wrRd,
  input  logic                   setLine,
  input  logic                   clrLine,
  input  logic [AW-1:0]          addr,
  input  logic [WIDTH-1:0]       din,
  output logic [WORDS*WIDTH-1:0] cellOut
);

  strobes_t         strobes;
  logic [WORDS-1:0] wordSel;
  logic             atBoundary;

  majram_ctrl #(.WORDS(WORDS), .ZONES(ZONES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .wrRd(wrRd),
    .setLine(setLine), .clrLine(clrLine), .addr(addr),
    .strobes(strobes), .wordSel(wordSel), .atBoundary(atBoundary)
  );

  majram_dp #(.WORDS(WORDS), .WIDTH(WIDTH), .ZONES(ZONES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordSel(wordSel),
    .din(din), .cellOut(cellOut)
  );

endmodule

// File: rtl/majram_checker.sv
module majram_checker #(
  parameter int NCELL = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             atBoundary,
  input logic             enable,
  input logic             wrRd,
  input logic             setLine,
  input logic             clrLine,
  input logic [NCELL-1:0] cellOut
);

  AST_FORCE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (atBoundary && setLine && clrLine) |-> ##5 (&cellOut)); // R2

  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (atBoundary && !setLine && !clrLine) |-> ##5 (cellOut == '0)); // R3

  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (atBoundary && enable && !wrRd && (setLine != clrLine)) |-> ##5 $stable(cellOut)); // R5

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (atBoundary && !enable && (setLine != clrLine)) |-> ##5 $stable(cellOut)); // R6

endmodule

bind majram_array majram_checker #(.NCELL(WORDS*WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .atBoundary(atBoundary), .enable(enable),
  .wrRd(wrRd), .setLine(setLine), .clrLine(clrLine), .cellOut(cellOut)
);

// File: tb/test_majram_array.sv
module test_majram_array;

  localparam int WORDS = 4;
  localparam int WIDTH = 4;
  localparam int AW    = 2;
  localparam int NVEC  = 12;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic                   enable, wrRd, setLine, clrLine;
  logic [AW-1:0]          addr;
  logic [WIDTH-1:0]       din;
  logic [WORDS*WIDTH-1:0] cellOut;

  int tests  = 0;
  int failed = 0;
  int cycles = 0;
  logic [WIDTH-1:0] model [WORDS];

  majram_array #(.WORDS(WORDS), .WIDTH(WIDTH)) i_majram_array (
    .clk(clk), .rstN(rstN), .enable(enable), .wrRd(wrRd), .setLine(setLine),
    .clrLine(clrLine), .addr(addr), .din(din), .cellOut(cellOut)
  );

  always #4 clk = ~clk;

  // {enable, wrRd, setLine, clrLine, addr[1:0], din[3:0], expected addressed word[3:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 4'hA, 4'hA},  // R4
    {1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 4'h5, 4'h5},  // R4
    {1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 4'hC, 4'hC},  // R4
    {1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 4'h3, 4'h3},  // R4
    {1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 4'hF, 4'h5},  // R5
    {1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h6, 4'h6},  // R7
    {1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 4'h0, 4'hC},  // R6
    {1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 4'h0, 4'hF},  // R2
    {1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 4'h9, 4'h9},  // R4
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 4'hF, 4'h0},  // R3
    {1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 4'h7, 4'h7},  // R4
    {1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 4'h0, 4'h7}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int w = 0; w < WORDS; w++) begin
      check(req, 32'(cellOut[w*WIDTH +: WIDTH]), 32'(model[w]));
    end
  endtask

  task automatic drive(input logic e, input logic wr, input logic s, input logic c,
                       input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    enable = e; wrRd = wr; setLine = s; clrLine = c; addr = a; din = d;
  endtask

  task automatic model_op(input logic e, input logic wr, input logic s, input logic c,
                          input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    if (s && c)        for (int w = 0; w < WORDS; w++) model[w] = '1;
    else if (!s && !c) for (int w = 0; w < WORDS; w++) model[w] = '0;
    else if (e && wr)  model[a] = d;
  endtask

  // Called at a negedge just before a sampling edge; returns at a negedge
  // just before the next sampling edge, after a full idle cycle.
  task automatic run_op(input logic e, input logic wr, input logic s, input logic c,
                        input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    drive(e, wr, s, c, a, d);
    repeat (4) @(posedge clk);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, '0, '0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    model_op(e, wr, s, c, a, d);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failed++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0, '1);
    for (int w = 0; w < WORDS; w++) model[w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 32'(cellOut), 32'd0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, '0, '0);
    rstN = 1'b1;
    check_all("R1 after reset");

    for (int i = 0; i < NVEC; i++) begin
      logic [13:0] v;
      v = VEC[i];
      run_op(v[13], v[12], v[11], v[10], v[9:8], v[7:4]);
      check($sformatf("vector %0d addressed word R2 R3 R4 R5 R6 R7", i),
            32'(cellOut[v[9:8]*WIDTH +: WIDTH]), 32'(v[3:0]));
      check_all($sformatf("vector %0d full array R6", i));
    end

    // R8: result not visible after the fourth edge, visible after the fifth
    drive(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 4'h5);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8 before fifth edge", 32'(cellOut[0 +: WIDTH]), 32'(model[0]));
    @(posedge clk);
    @(negedge clk);
    check("R8 after fifth edge", 32'(cellOut[0 +: WIDTH]), 32'h5);
    model[0] = 4'h5;
    drive(1'b0, 1'b0, 1'b0, 1'b1, '0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);

    // Back-to-back force then write into different words
    run_op(1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 4'h0);
    check_all("R2 back-to-back force high");
    run_op(1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 4'h2);
    check_all("R4 write after force");
    run_op(1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4'hB);
    check_all("R7 write with swapped lines");

    // R9: long idle retention
    repeat (40) @(posedge clk);
    @(negedge clk);
    check_all("R9 idle retention");

    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule